// File: doc/BRIEF.md
# HDLC Receive Descriptor-Chain DMA Engine

This engine takes the byte stream from a serial HDLC receiver and writes it into buffers in shared memory. A host processor builds a linked list of six-word descriptors. Each descriptor names a buffer, gives its size in 16-bit words, carries two control bits and points to the next descriptor. The engine reads each descriptor over a 16-bit memory port that uses 24-bit word addresses and a request/acknowledge handshake. It packs incoming bytes two to a word. When a buffer fills or a frame ends, it writes a status word back into the descriptor, and then it moves on to the next descriptor.

The host starts the engine with a command pulse that carries the byte address of the first descriptor. Descriptors whose size is zero are passed over. A descriptor with its end-of-queue bit set stops the engine: it raises an interrupt and stays idle until the next command. A descriptor with its completion-interrupt bit set raises an interrupt once its status word has been written.

The control sequencer has six states:
- IDLE: waits for a command.
- FETCH: reads descriptor words 0 to 4.
- DECIDE: tests end-of-queue, then the size.
- RECV: takes bytes and frame ends.
- WDATA: writes one packed data word.
- WSTAT: writes the status word.

Its transitions are:
- IDLE→FETCH on a command.
- FETCH→DECIDE on the acknowledge of word 4.
- DECIDE→IDLE on end-of-queue.
- DECIDE→FETCH on zero size.
- DECIDE→RECV otherwise.
- RECV→WDATA when a word is complete, when the capacity is reached, or when a frame ends on an odd byte.
- RECV→WSTAT when a frame ends on an even byte count.
- WDATA→RECV, or WDATA→WSTAT when the buffer is full or a frame is closing.
- WSTAT→FETCH on acknowledge.

Top module: `hdlc_rx_desc_dma`

## Requirements
- R1: While reset is held, mem_req_o, irq_o and rx_ready_o are all low.
- R2: After a command pulse in IDLE, the engine reads descriptor words 0..4 in that order. Word i is read at word address (pointer>>1)+i, with mem_we_o low. Word 0 and the low byte of word 1 form the next-descriptor byte address. Words 2 and 3 form the buffer byte address in the same way. In word 4, bits 11:0 are the size in words, bit 14 is the completion-interrupt enable and bit 15 is end-of-queue.
- R3: Once mem_req_o is raised, it stays high until mem_ack_i, with address, write enable and write data unchanged.
- R4: Received bytes are stored two per word, the first in bits 7:0 and the second in bits 15:8. Data words go to consecutive word addresses starting at (buffer pointer>>1).
- R5: When a frame ends after an odd number of bytes, the last word is written with bits 15:8 zero. The status word is written only after that data word.
- R6: The status word goes to descriptor word 5. Its bit 15 is set when the frame ends with no error. The end-flag input rx_err_i[3:0] (bit 3 bad CRC, bit 2 abort, bit 1 overflow, bit 0 not a whole number of bytes) appears in status bits 14..11. Bits 10:0 hold the number of bytes stored in this buffer.
- R7: A buffer is full when its byte count reaches the smaller of twice its size and 2047. The engine then writes a status word with flag bits 15:11 clear and the count in bits 10:0, and the frame continues in the next descriptor's buffer.
- R8: With a size of 2048 words, the buffer takes 2047 bytes. The 2047th byte is written with a zero high byte, and the count reads 2047.
- R9: A descriptor whose size is zero causes no write. The engine goes straight on to fetch the descriptor at its next pointer.
- R10: When the completion-interrupt bit is set, irq_o pulses for one cycle after each status write of that descriptor. When the bit is clear, there is no pulse.
- R11: A descriptor with end-of-queue set causes one irq_o pulse and no write. The engine then makes no memory request and keeps rx_ready_o low until the next command, which starts a new fetch at the commanded pointer.
- R12: rx_ready_o is high only in the receive state and never while mem_req_o is high. A byte or frame end is taken only in a cycle where rx_ready_o is high. When a frame end and a byte arrive in the same cycle, the frame end wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Receive command pulse, acted on in IDLE |
| start_ptr_i | input | 24 | Byte address of the first descriptor |
| rx_valid_i | input | 1 | A received byte is offered |
| rx_byte_i | input | 8 | Received byte |
| rx_end_i | input | 1 | End of the current frame is offered |
| rx_err_i | input | 4 | End flags: bit 3 bad CRC, bit 2 abort, bit 1 overflow, bit 0 partial byte |
| rx_ready_o | output | 1 | Byte or frame end is taken this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 24 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 16 | Read data, valid with mem_ack_i |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench aims at these edges:
- A frame that ends on an odd byte. A design that wrote the status first, or left stale data in the high byte, would misreport the frame's tail.
- A buffer that fills in the same beat as a word completes, followed by a frame end arriving with zero bytes in the next buffer. An off-by-one capacity test would write past the buffer or drop the zero-count status.
- The 2048-word buffer. Here a design that did not saturate the count would wrap the 11-bit field.
- A zero-size descriptor and an end-of-queue descriptor reached straight after a status write. A design that got either one wrong would write into a skipped buffer, keep fetching past the queue end, or miss the interrupt and the restart at the new pointer.

// File: rtl/hdlc_rxd_pkg.sv
`timescale 1ns/1ps
package hdlc_rxd_pkg;
    localparam int DESC_WORDS = 6;
    localparam int HOST_WORDS = 5;
    localparam int STAT_WORD  = 5;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int ERR_W      = 4;
    localparam int CNT_W      = 11;
    localparam int EOQ_BIT    = 15;
    localparam int IBC_BIT    = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECIDE,
        ST_RECV,
        ST_WDATA,
        ST_WSTAT
    } rxd_state_e;
endpackage

// File: rtl/hdlc_rxd_desc.sv
`timescale 1ns/1ps
// Holds the host-written descriptor fields captured during a fetch.
module hdlc_rxd_desc
    import hdlc_rxd_pkg::*;
#(
    parameter int AW     = 24,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en_i,
    input  logic [IDX_W-1:0]  cap_idx_i,
    input  logic [15:0]       cap_word_i,
    output logic [AW-1:0]     next_ptr_o,
    output logic [AW-1:0]     buf_ptr_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              ibc_o,
    output logic              eoq_o
);
    localparam int HI_W = AW - 16;

    logic [15:0]     nxt_lo_q, buf_lo_q;
    logic [HI_W-1:0] nxt_hi_q, buf_hi_q;
    logic [SIZE_W-1:0] size_q;
    logic            ibc_q, eoq_q;
    logic            unused_ctl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nxt_lo_q <= '0;
            nxt_hi_q <= '0;
            buf_lo_q <= '0;
            buf_hi_q <= '0;
            size_q   <= '0;
            ibc_q    <= 1'b0;
            eoq_q    <= 1'b0;
        end else if (cap_en_i) begin
            case (cap_idx_i)
                IDX_W'(0): nxt_lo_q <= cap_word_i;
                IDX_W'(1): nxt_hi_q <= cap_word_i[HI_W-1:0];
                IDX_W'(2): buf_lo_q <= cap_word_i;
                IDX_W'(3): buf_hi_q <= cap_word_i[HI_W-1:0];
                IDX_W'(4): begin
                    size_q <= cap_word_i[SIZE_W-1:0];
                    ibc_q  <= cap_word_i[IBC_BIT];
                    eoq_q  <= cap_word_i[EOQ_BIT];
                end
                default: ;
            endcase
        end
    end

    assign unused_ctl = ^{cap_word_i[15:HI_W], cap_word_i[13:SIZE_W]};

    assign next_ptr_o = {nxt_hi_q, nxt_lo_q};
    assign buf_ptr_o  = {buf_hi_q, buf_lo_q};
    assign size_o     = size_q;
    assign ibc_o      = ibc_q;
    assign eoq_o      = eoq_q;
endmodule

// File: rtl/hdlc_rxd_pack.sv
`timescale 1ns/1ps
// Byte-to-word packer with byte counter, word index and buffer capacity test.
module hdlc_rxd_pack #(
    parameter int SIZE_W = 12,
    parameter int CNT_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              take_i,
    input  logic [7:0]        byte_i,
    input  logic              word_ack_i,
    output logic              pend_o,
    output logic              flush_o,
    output logic              at_cap_o,
    output logic [15:0]       word_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [SIZE_W-1:0] widx_o
);
    localparam int DBL_W   = SIZE_W + 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [DBL_W-1:0]  dbl_bytes;
    logic [CNT_W-1:0]  cap;
    logic [CNT_W-1:0]  count_q, count_inc;
    logic [SIZE_W-1:0] widx_q;
    logic [7:0]        lo_q, hi_q;
    logic              pend_q, hi_v_q;

    assign dbl_bytes = {size_i, 1'b0};
    assign cap       = (dbl_bytes > DBL_W'(CNT_MAX)) ? CNT_W'(CNT_MAX)
                                                     : dbl_bytes[CNT_W-1:0];
    assign count_inc = count_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            widx_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            pend_q  <= 1'b0;
            hi_v_q  <= 1'b0;
        end else if (clr_i) begin
            count_q <= '0;
            widx_q  <= '0;
            pend_q  <= 1'b0;
            hi_v_q  <= 1'b0;
        end else begin
            if (take_i) begin
                count_q <= count_inc;
                if (!pend_q) begin
                    lo_q   <= byte_i;
                    pend_q <= 1'b1;
                end else begin
                    hi_q   <= byte_i;
                    hi_v_q <= 1'b1;
                end
            end
            if (word_ack_i) begin
                pend_q <= 1'b0;
                hi_v_q <= 1'b0;
                widx_q <= widx_q + 1'b1;
            end
        end
    end

    assign pend_o   = pend_q;
    assign flush_o  = take_i && (pend_q || (count_inc == cap));
    assign at_cap_o = (count_q == cap);
    assign word_o   = {hi_v_q ? hi_q : 8'h00, lo_q};
    assign count_o  = count_q;
    assign widx_o   = widx_q;
endmodule

// File: rtl/hdlc_rx_desc_dma.sv
`timescale 1ns/1ps
// Receive descriptor-chain DMA: fetch, pack, write back, follow the chain.
module hdlc_rx_desc_dma
    import hdlc_rxd_pkg::*;
#(
    parameter int AW     = 24,
    parameter int SIZE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    start_ptr_i,
    input  logic             rx_valid_i,
    input  logic [7:0]       rx_byte_i,
    input  logic             rx_end_i,
    input  logic [ERR_W-1:0] rx_err_i,
    output logic             rx_ready_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [15:0]      mem_wdata_o,
    input  logic             mem_ack_i,
    input  logic [15:0]      mem_rdata_i,
    output logic             irq_o
);
    rxd_state_e state_q, state_d;

    logic [AW-1:0]    desc_ptr_q;
    logic [IDX_W-1:0] fidx_q;
    logic [ERR_W-1:0] err_q;
    logic             closing_q;
    logic             irq_q;

    logic [AW-1:0]     d_next, d_buf;
    logic [SIZE_W-1:0] d_size;
    logic              d_ibc, d_eoq;

    logic              pk_pend, pk_flush, pk_at_cap;
    logic [15:0]       pk_word;
    logic [CNT_W-1:0]  pk_count;
    logic [SIZE_W-1:0] pk_widx;

    logic [AW-1:0] desc_wbase, buf_wbase;
    logic [15:0]   stat_word;
    logic          frame_ok;
    logic          take_byte;

    hdlc_rxd_desc #(.AW(AW), .SIZE_W(SIZE_W)) u_desc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (state_q == ST_FETCH && mem_ack_i),
        .cap_idx_i  (fidx_q),
        .cap_word_i (mem_rdata_i),
        .next_ptr_o (d_next),
        .buf_ptr_o  (d_buf),
        .size_o     (d_size),
        .ibc_o      (d_ibc),
        .eoq_o      (d_eoq)
    );

    assign take_byte = (state_q == ST_RECV) && rx_valid_i && !rx_end_i;

    hdlc_rxd_pack #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (state_q == ST_DECIDE),
        .size_i     (d_size),
        .take_i     (take_byte),
        .byte_i     (rx_byte_i),
        .word_ack_i (state_q == ST_WDATA && mem_ack_i),
        .pend_o     (pk_pend),
        .flush_o    (pk_flush),
        .at_cap_o   (pk_at_cap),
        .word_o     (pk_word),
        .count_o    (pk_count),
        .widx_o     (pk_widx)
    );

    assign desc_wbase = AW'(desc_ptr_q[AW-1:1]);
    assign buf_wbase  = AW'(d_buf[AW-1:1]);
    assign frame_ok   = closing_q && (err_q == '0);
    assign stat_word  = {frame_ok, err_q, pk_count};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_FETCH;
            ST_FETCH:  if (mem_ack_i && fidx_q == IDX_W'(HOST_WORDS - 1))
                           state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (d_eoq)              state_d = ST_IDLE;
                else if (d_size == '0)  state_d = ST_FETCH;
                else                    state_d = ST_RECV;
            end
            ST_RECV: begin
                if (rx_end_i)      state_d = pk_pend ? ST_WDATA : ST_WSTAT;
                else if (pk_flush) state_d = ST_WDATA;
            end
            ST_WDATA:  if (mem_ack_i)
                           state_d = (closing_q || pk_at_cap) ? ST_WSTAT : ST_RECV;
            ST_WSTAT:  if (mem_ack_i) state_d = ST_FETCH;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Sequencer datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            desc_ptr_q <= '0;
            fidx_q     <= '0;
            err_q      <= '0;
            closing_q  <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    fidx_q <= '0;
                    if (start_i) desc_ptr_q <= start_ptr_i;
                end
                ST_FETCH: if (mem_ack_i) fidx_q <= fidx_q + 1'b1;
                ST_DECIDE: begin
                    fidx_q    <= '0;
                    err_q     <= '0;
                    closing_q <= 1'b0;
                    if (d_eoq)              irq_q      <= 1'b1;
                    else if (d_size == '0)  desc_ptr_q <= d_next;
                end
                ST_RECV: if (rx_end_i) begin
                    err_q     <= rx_err_i;
                    closing_q <= 1'b1;
                end
                ST_WDATA: ;
                ST_WSTAT: begin
                    fidx_q <= '0;
                    if (mem_ack_i) begin
                        desc_ptr_q <= d_next;
                        irq_q      <= d_ibc;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rx_ready_o  = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = desc_wbase + AW'(fidx_q);
            end
            ST_RECV:  rx_ready_o = 1'b1;
            ST_WDATA: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = buf_wbase + AW'(pk_widx);
                mem_wdata_o = pk_word;
            end
            ST_WSTAT: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = desc_wbase + AW'(STAT_WORD);
                mem_wdata_o = stat_word;
            end
            default: ;
        endcase
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/hdlc_rxd_chk.sv
`timescale 1ns/1ps
module hdlc_rxd_chk
    import hdlc_rxd_pkg::*;
#(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          rx_ready_o,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [15:0]   mem_wdata_o,
    input logic          mem_ack_i,
    input logic          irq_o,
    input rxd_state_e    state_q
);
    // R3: request held stable until acknowledged
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_we_o) && $stable(mem_wdata_o));

    // R12: bytes are only offered for acceptance while receiving, never beside a request
    assert_ready_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready_o |-> !mem_req_o && state_q == ST_RECV);

    // R10: the interrupt is a single-cycle pulse
    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R2: a command in idle starts a descriptor read
    assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && start_i |=> mem_req_o && !mem_we_o);

    // R11: an idle engine is quiet on the memory port and the byte port
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !mem_req_o && !rx_ready_o);

    // R1: nothing is driven while reset is held
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!mem_req_o && !irq_o && !rx_ready_o);
        end
    end
endmodule

bind hdlc_rx_desc_dma hdlc_rxd_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rx_ready_o  (rx_ready_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_ack_i   (mem_ack_i),
    .irq_o       (irq_o),
    .state_q     (state_q)
);

// File: tb/hdlc_rx_desc_dma_tb.sv
`timescale 1ns/1ps
module hdlc_rx_desc_dma_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] start_ptr_i = '0;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  rx_byte_i = '0;
    logic        rx_end_i = 1'b0;
    logic [3:0]  rx_err_i = '0;
    logic        rx_ready_o, mem_req_o, mem_we_o, irq_o;
    logic [23:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic        mem_ack_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;

    always #2.5 clk = ~clk;

    hdlc_rx_desc_dma u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_ptr_i(start_ptr_i),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .rx_end_i(rx_end_i),
        .rx_err_i(rx_err_i), .rx_ready_o(rx_ready_o), .mem_req_o(mem_req_o),
        .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // Behavioural shared memory and expected-access queue
    logic [15:0] mem [int];
    typedef struct { bit we; int addr; logic [15:0] data; string tag; } acc_t;
    acc_t expq[$];
    logic [7:0] lf = 8'hA5;
    int irq_seen = 0;
    int exp_irq = 0;

    function automatic logic [15:0] rd(input int a);
        return mem.exists(a) ? mem[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        if (irq_o) irq_seen++;
        if (rx_ready_o) check(!mem_req_o, "R12", "ready beside request", 1, 0);
        if (!rst_n || mem_ack_i) begin
            mem_ack_i = 1'b0;
        end else if (mem_req_o && lf[0]) begin
            acc_t e;
            mem_ack_i = 1'b1;
            mem_rdata_i = rd(int'(mem_addr_o));
            if (mem_we_o) mem[int'(mem_addr_o)] = mem_wdata_o;
            if (expq.size() == 0) begin
                check(0, "R2", "unexpected access addr", longint'(mem_addr_o), 0);
            end else begin
                e = expq.pop_front();
                check(mem_we_o == e.we && int'(mem_addr_o) == e.addr, e.tag,
                      "access kind/addr", {mem_we_o, mem_addr_o}, {e.we, e.addr[23:0]});
                if (e.we)
                    check(mem_wdata_o == e.data, e.tag, "write data",
                          longint'(mem_wdata_o), longint'(e.data));
            end
        end
    end

    // Transaction-level reference model
    int m_ptr, m_next, m_buf, m_cap, m_bytes, m_widx;
    bit m_pend, m_ibc, m_halt;
    logic [7:0] m_lo;
    string rtag;

    function automatic void push(input bit we, input int a, input logic [15:0] d, input string t);
        acc_t e;
        e.we = we; e.addr = a; e.data = d; e.tag = t;
        expq.push_back(e);
    endfunction

    function automatic void m_enter();
        logic [15:0] w4;
        int sz;
        forever begin
            for (int i = 0; i < 5; i++) push(0, m_ptr / 2 + i, 16'h0, rtag);
            w4 = rd(m_ptr / 2 + 4);
            m_next = int'(rd(m_ptr / 2)) | (int'(rd(m_ptr / 2 + 1) & 16'h00FF) << 16);
            if (w4[15]) begin
                exp_irq++;
                m_halt = 1;
                return;
            end
            sz = int'(w4[11:0]);
            if (sz == 0) begin
                m_ptr = m_next;
                rtag = "R9";
            end else begin
                m_buf = (int'(rd(m_ptr / 2 + 2)) | (int'(rd(m_ptr / 2 + 3) & 16'h00FF) << 16)) / 2;
                m_cap = (2 * sz > 2047) ? 2047 : 2 * sz;
                m_ibc = w4[14];
                m_bytes = 0; m_widx = 0; m_pend = 0;
                rtag = "R2";
                return;
            end
        end
    endfunction

    function automatic void m_status(input logic [15:0] s, input string t);
        push(1, m_ptr / 2 + 5, s, t);
        if (m_ibc) exp_irq++;
        m_ptr = m_next;
        m_enter();
    endfunction

    function automatic void m_byte(input logic [7:0] b);
        m_bytes++;
        if (!m_pend) begin
            m_lo = b;
            m_pend = 1;
            if (m_bytes == m_cap) begin
                push(1, m_buf + m_widx, {8'h00, m_lo}, "R8");
                m_widx++; m_pend = 0;
                m_status(16'(m_bytes), "R8");
            end
        end else begin
            push(1, m_buf + m_widx, {b, m_lo}, "R4");
            m_widx++; m_pend = 0;
            if (m_bytes == m_cap) m_status(16'(m_bytes), "R7");
        end
    endfunction

    function automatic void m_end(input logic [3:0] f);
        if (m_pend) begin
            push(1, m_buf + m_widx, {8'h00, m_lo}, "R5");
            m_pend = 0;
        end
        m_status({f == 4'h0, f, m_bytes[10:0]}, "R6");
    endfunction

    // Drivers, called at a falling edge
    task automatic send_byte(input logic [7:0] b);
        m_byte(b);
        rx_byte_i = b; rx_valid_i = 1'b1;
        while (!rx_ready_o) @(negedge clk);
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic send_end(input logic [3:0] f);
        m_end(f);
        rx_err_i = f; rx_end_i = 1'b1;
        while (!rx_ready_o) @(negedge clk);
        @(negedge clk);
        rx_end_i = 1'b0; rx_err_i = '0;
    endtask

    task automatic start(input int p);
        m_ptr = p; m_halt = 0; rtag = "R2";
        m_enter();
        start_ptr_i = 24'(p); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic put_desc(input int a, input int nxt, input int bufa, input int sz,
                            input bit ibc, input bit eoq);
        mem[a / 2 + 0] = nxt[15:0];
        mem[a / 2 + 1] = {8'h00, nxt[23:16]};
        mem[a / 2 + 2] = bufa[15:0];
        mem[a / 2 + 3] = {8'h00, bufa[23:16]};
        mem[a / 2 + 4] = {eoq, ibc, 2'b00, sz[11:0]};
        mem[a / 2 + 5] = 16'hDEAD;
    endtask

    task automatic settle_and_check(input string phase);
        int busy = 0;
        repeat (120) @(negedge clk);
        check(expq.size() == 0, "R6", {phase, " pending accesses"}, expq.size(), 0);
        check(irq_seen == exp_irq, "R10", {phase, " irq count"}, irq_seen, exp_irq);
        check(m_halt == 1, "R11", {phase, " model halted"}, m_halt, 1);
        repeat (30) begin
            @(negedge clk);
            if (mem_req_o || rx_ready_o) busy++;
        end
        check(busy == 0, "R11", {phase, " quiet after end-of-queue"}, busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R11", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!mem_req_o && !irq_o && !rx_ready_o, "R1", "outputs in reset",
              {mem_req_o, irq_o, rx_ready_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!mem_req_o && !rx_ready_o, "R1", "idle after reset",
              {mem_req_o, rx_ready_o}, 0);

        // Chain: A(4 words, irq) -> B(zero) -> C(2 words) -> D(8 words, irq) -> E(end)
        put_desc(24'h000100, 24'h000120, 24'h001000, 4, 1, 0);
        put_desc(24'h000120, 24'h000140, 24'h001800, 0, 1, 0);
        put_desc(24'h000140, 24'h000160, 24'h002000, 2, 0, 0);
        put_desc(24'h000160, 24'h000180, 24'h013000, 8, 1, 0);
        put_desc(24'h000180, 24'h000100, 24'h005000, 3, 1, 1);
        // J(1 word) -> K(4 words, irq) -> E
        put_desc(24'h000200, 24'h000220, 24'h006000, 1, 0, 0);
        put_desc(24'h000220, 24'h000180, 24'h006100, 4, 1, 0);
        // F(2048 words, irq) -> G(1 word, irq) -> E
        put_desc(24'h000300, 24'h000320, 24'h020000, 2048, 1, 0);
        put_desc(24'h000320, 24'h000180, 24'h007000, 1, 1, 0);

        // Odd-length good frame, then a split frame with bad CRC
        start(24'h000100);
        for (int i = 0; i < 5; i++) send_byte(8'(8'h11 * (i + 1)));
        send_end(4'b0000);
        for (int i = 0; i < 6; i++) send_byte(8'(8'hA0 + 3 * i));
        send_end(4'b1000);
        settle_and_check("chain1");

        // Buffer fills exactly, frame end arrives with zero bytes in next buffer
        start(24'h000200);
        send_byte(8'h5A);
        send_byte(8'hC3);
        send_end(4'b0010);
        settle_and_check("chain2");

        // Saturated count on a 2048-word buffer, then abort + partial byte
        start(24'h000300);
        for (int i = 0; i < 2047; i++) send_byte(8'(i * 37 + 5));
        send_byte(8'h7E);
        send_end(4'b0101);
        settle_and_check("chain3");

        check(rd(24'h001000 / 2) == 16'h2211, "R4", "first packed word",
              rd(24'h001000 / 2), 16'h2211);
        check(rd(24'h001800 / 2) == 16'h0000, "R9", "skipped buffer untouched",
              rd(24'h001800 / 2), 0);
        check(rd(24'h000120 / 2 + 5) == 16'hDEAD, "R9", "skipped status untouched",
              rd(24'h000120 / 2 + 5), 16'hDEAD);
        check(rd(24'h005000 / 2) == 16'h0000, "R11", "queue-end buffer untouched",
              rd(24'h005000 / 2), 0);
        finish_run();
    end
endmodule